// File: doc/BRIEF.md
# DSD Capture Phase Selector with Resync Mute

This block sits in front of a multi-channel DSD decimation filter. All six 1-bit streams are sampled in the master clock domain. Two copies of the stream are kept. Buffer A loads on each rising edge of the DSD bit clock. Buffer B loads from buffer A on each falling edge, so it trails by half a bit period. On every word boundary, meaning a rising edge of the word clock, the block hands one of the two buffers to the filter. Which buffer it hands over is a fixed choice, and that choice is set by a resynchronization sequence.

A resync starts on the release of the active-low init input or on a rising edge of the sync input. The block first waits for the next falling edge of the bit clock. There it samples a phase flag, which is the parity of bit-clock rising edges counted since reset. At the next word boundary that flag becomes the buffer choice. Starting from that same boundary, a mute request is held for a rate-dependent number of word boundaries. This covers the one DSD sample that a resync may drop or repeat.

Top module: `dsd_phase_resync`

## Requirements
- R1: On a cycle in which `dsd_bclk_i` is high and was low in the previous master-clock cycle, buffer A loads `dsd_data_i`. At all other times buffer A holds its value.
- R2: On a cycle in which `dsd_bclk_i` is low and was high in the previous cycle, buffer B loads the value buffer A held before that edge.
- R3: A phase bit starts at 0 after reset and inverts on every bit-clock rising edge. The flag is the value this bit has at the first bit-clock falling edge after a resync request.
- R4: At the first word boundary after the flag has been sampled, `sel_b_o` (0 = buffer A, 1 = buffer B) takes the flag's value. It stays unchanged until the next such boundary.
- R5: Each word boundary makes `filt_valid_o` high for exactly the next cycle. At the same time `filt_data_o` shows the selected buffer as it stood before that edge. At the boundary that applies a new choice, the new choice is the one used.
- R6: `rate_i` is read at the boundary that applies a choice: 0 means fs, 1 means 2fs, and 2 or 3 mean 4fs. After that boundary, `mute_o` stays high through 9, 17 or 35 further word boundaries. It goes low one cycle after the 10th, 18th or 36th further boundary.
- R7: `mute_o` is high from the cycle after a resync request until the applying boundary.
- R8: A request is a rising edge of `init_ni` or of `resync_i`. A new request while a resync is pending restarts the sequence. A request that arrives on the same cycle as a bit-clock falling edge takes priority over that edge, so the flag is sampled at the following falling edge.
- R9: While `rst_ni` is low, `filt_valid_o`, `filt_data_o`, `sel_b_o` and `mute_o` are all 0. This holds even when reset is asserted in the middle of operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock (512fs) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dsd_bclk_i | input | 1 | DSD bit clock, synchronous to clk_i |
| dsd_data_i | input | NCH | One DSD bit per channel |
| word_clk_i | input | 1 | PCM word clock; its rising edge is the word boundary |
| init_ni | input | 1 | Init, active low; release requests a resync |
| resync_i | input | 1 | Rising edge requests a resync |
| rate_i | input | 2 | Output rate code, sets mute length |
| filt_data_o | output | NCH | Selected DSD bits for the filter |
| filt_valid_o | output | 1 | One-cycle strobe after each word boundary |
| sel_b_o | output | 1 | Current choice: 1 = delayed buffer |
| mute_o | output | 1 | Mute request for downstream outputs |

## Verification
The assertions assume that every input changes synchronously to the master clock. They also assume that the bit clock and the word clock each stay at a level for at least one cycle between edges, so that edge strobes never land on consecutive cycles. The stimulus drives every input on the falling master-clock edge. It derives the bit clock as the master clock divided by 8, with a selectable phase offset, and uses a 42-cycle word clock that drifts against it. Init and sync pulses last at least 6 cycles, except in the case where a request is deliberately placed on a bit-clock falling edge.

// File: rtl/dsd_rsync_pkg.sv
package dsd_rsync_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE      = 2'd0,
    SEQ_WAIT_FALL = 2'd1,
    SEQ_WAIT_WORD = 2'd2
  } seq_state_e;

  typedef enum logic [1:0] {
    RATE_1X  = 2'd0,
    RATE_2X  = 2'd1,
    RATE_4X  = 2'd2,
    RATE_RSV = 2'd3
  } rate_e;

  // edge detector lanes
  localparam int unsigned EI_BCLK   = 0;
  localparam int unsigned EI_BCLK_N = 1;
  localparam int unsigned EI_WORD   = 2;
  localparam int unsigned EI_INIT   = 3;
  localparam int unsigned EI_SYNC   = 4;
  localparam int unsigned EDGE_W    = 5;
endpackage

// File: rtl/dsd_edge_det.sv
module dsd_edge_det #(
  parameter int unsigned   W       = 1,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= RST_VAL;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/dsd_dual_capture.sv
module dsd_dual_capture #(
  parameter int unsigned NCH = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           bclk_rise_i,
  input  logic           bclk_fall_i,
  input  logic [NCH-1:0] data_i,
  output logic [NCH-1:0] buf_a_o,
  output logic [NCH-1:0] buf_b_o,
  output logic           phase_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_a_o <= '0;
      phase_o <= 1'b0;
    end else if (bclk_rise_i) begin
      buf_a_o <= data_i;
      phase_o <= ~phase_o;
    end
  end

  // half-period delayed copy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          buf_b_o <= '0;
    else if (bclk_fall_i) buf_b_o <= buf_a_o;
  end
endmodule

// File: rtl/dsd_phase_seq.sv
module dsd_phase_seq
  import dsd_rsync_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic bclk_fall_i,
  input  logic word_rise_i,
  input  logic phase_i,
  output logic sel_next_o,
  output logic sel_b_o,
  output logic apply_o,
  output logic busy_o
);
  seq_state_e state_q;
  logic       flag_q;

  always_comb begin
    apply_o    = (state_q == SEQ_WAIT_WORD) && word_rise_i && !req_i;
    sel_next_o = apply_o ? flag_q : sel_b_o;
    busy_o     = (state_q != SEQ_IDLE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      flag_q  <= 1'b0;
    end else if (req_i) begin
      state_q <= SEQ_WAIT_FALL;
    end else begin
      unique case (state_q)
        SEQ_IDLE: ;
        SEQ_WAIT_FALL:
          if (bclk_fall_i) begin
            flag_q  <= phase_i;
            state_q <= SEQ_WAIT_WORD;
          end
        SEQ_WAIT_WORD:
          if (word_rise_i) state_q <= SEQ_IDLE;
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_b_o <= 1'b0;
    else if (apply_o) sel_b_o <= flag_q;
  end
endmodule

// File: rtl/dsd_mute_timer.sv
module dsd_mute_timer
  import dsd_rsync_pkg::*;
#(
  parameter int unsigned LEN_1X = 10,
  parameter int unsigned LEN_2X = 18,
  parameter int unsigned LEN_4X = 36
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] rate_i,
  input  logic       apply_i,
  input  logic       word_rise_i,
  input  logic       busy_i,
  output logic       mute_o
);
  localparam int unsigned MAX_A = (LEN_1X > LEN_2X) ? LEN_1X : LEN_2X;
  localparam int unsigned MAX_L = (MAX_A > LEN_4X) ? MAX_A : LEN_4X;
  localparam int unsigned CNT_W = $clog2(MAX_L + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    unique case (rate_e'(rate_i))
      RATE_1X: load_val = CNT_W'(LEN_1X);
      RATE_2X: load_val = CNT_W'(LEN_2X);
      default: load_val = CNT_W'(LEN_4X);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (apply_i)                    cnt_q <= load_val;
    else if (word_rise_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign mute_o = busy_i || (cnt_q != '0);
endmodule

// File: rtl/dsd_phase_resync.sv
module dsd_phase_resync
  import dsd_rsync_pkg::*;
#(
  parameter int unsigned NCH    = 6,
  parameter int unsigned MUTE_1X = 10,
  parameter int unsigned MUTE_2X = 18,
  parameter int unsigned MUTE_4X = 36
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           dsd_bclk_i,
  input  logic [NCH-1:0] dsd_data_i,
  input  logic           word_clk_i,
  input  logic           init_ni,
  input  logic           resync_i,
  input  logic [1:0]     rate_i,
  output logic [NCH-1:0] filt_data_o,
  output logic           filt_valid_o,
  output logic           sel_b_o,
  output logic           mute_o
);
  localparam logic [EDGE_W-1:0] EDGE_RST = EDGE_W'(1) << EI_BCLK_N;

  logic [EDGE_W-1:0] edge_sig, edge_rise;
  logic              bclk_rise, bclk_fall, word_rise, req;
  logic [NCH-1:0]    buf_a, buf_b;
  logic              phase, sel_next, apply, busy;

  always_comb begin
    edge_sig            = '0;
    edge_sig[EI_BCLK]   = dsd_bclk_i;
    edge_sig[EI_BCLK_N] = ~dsd_bclk_i;
    edge_sig[EI_WORD]   = word_clk_i;
    edge_sig[EI_INIT]   = init_ni;
    edge_sig[EI_SYNC]   = resync_i;
  end

  dsd_edge_det #(.W(EDGE_W), .RST_VAL(EDGE_RST)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (edge_sig),
    .rise_o(edge_rise)
  );

  assign bclk_rise = edge_rise[EI_BCLK];
  assign bclk_fall = edge_rise[EI_BCLK_N];
  assign word_rise = edge_rise[EI_WORD];
  assign req       = edge_rise[EI_INIT] | edge_rise[EI_SYNC];

  dsd_dual_capture #(.NCH(NCH)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bclk_rise_i(bclk_rise),
    .bclk_fall_i(bclk_fall),
    .data_i     (dsd_data_i),
    .buf_a_o    (buf_a),
    .buf_b_o    (buf_b),
    .phase_o    (phase)
  );

  dsd_phase_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req),
    .bclk_fall_i(bclk_fall),
    .word_rise_i(word_rise),
    .phase_i    (phase),
    .sel_next_o (sel_next),
    .sel_b_o    (sel_b_o),
    .apply_o    (apply),
    .busy_o     (busy)
  );

  dsd_mute_timer #(.LEN_1X(MUTE_1X), .LEN_2X(MUTE_2X), .LEN_4X(MUTE_4X)) u_mute (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rate_i     (rate_i),
    .apply_i    (apply),
    .word_rise_i(word_rise),
    .busy_i     (busy),
    .mute_o     (mute_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_data_o  <= '0;
      filt_valid_o <= 1'b0;
    end else begin
      filt_valid_o <= word_rise;
      if (word_rise) filt_data_o <= sel_next ? buf_b : buf_a;
    end
  end
endmodule

// File: rtl/dsd_phase_resync_chk.sv
module dsd_phase_resync_chk #(
  parameter int unsigned NCH = 6
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           req_i,
  input logic           bclk_rise_i,
  input logic           bclk_fall_i,
  input logic           word_rise_i,
  input logic [NCH-1:0] buf_a_i,
  input logic [NCH-1:0] buf_b_i,
  input logic           sel_b_i,
  input logic           mute_i,
  input logic           valid_i
);
  p_bufa_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bclk_rise_i |=> $stable(buf_a_i));

  p_bufb_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bclk_fall_i |=> (buf_b_i == $past(buf_a_i)));

  p_sel_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_rise_i |=> $stable(sel_b_i));

  p_valid_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> $past(word_rise_i));

  p_valid_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  p_mute_on_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> mute_i);
endmodule

bind dsd_phase_resync dsd_phase_resync_chk #(.NCH(NCH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req),
  .bclk_rise_i(bclk_rise),
  .bclk_fall_i(bclk_fall),
  .word_rise_i(word_rise),
  .buf_a_i    (buf_a),
  .buf_b_i    (buf_b),
  .sel_b_i    (sel_b_o),
  .mute_i     (mute_o),
  .valid_i    (filt_valid_o)
);

// File: tb/tb_dsd_phase_resync.sv
`timescale 1ns/1ps
module tb_dsd_phase_resync;
  localparam int NCH = 6;
  localparam int WP  = 42;
  localparam int NV  = 6;
  // boff, rate, use_init, delay, expected mute length
  localparam int VEC [NV][5] = '{
    '{0, 0, 1, 0, 10}, '{3, 1, 0, 8, 18}, '{5, 2, 0, 3, 36},
    '{1, 3, 1, 13, 36}, '{6, 0, 0, 21, 10}, '{2, 1, 1, 5, 18}};

  logic clk_i = 0, rst_ni = 0;
  logic dsd_bclk_i = 0, word_clk_i = 0, init_ni = 0, resync_i = 0;
  logic [NCH-1:0] dsd_data_i = '0;
  logic [1:0] rate_i = '0;
  logic [NCH-1:0] filt_data_o;
  logic filt_valid_o, sel_b_o, mute_o;

  dsd_phase_resync #(.NCH(NCH)) dut (.*);

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0, cyc = 0, boff = 0, ea = -1, mute_n = 10, mute_exp = 10;
  int st = 0;
  bit finished = 0, drv_init = 0, drv_sync = 0;
  bit pb = 0, pw = 0, pi = 0, ps = 0, par = 0, flag = 0, sel = 0;
  logic [NCH-1:0] a_val = '0, b_val = '0, exp_data = '0;
  bit c_valid = 0, c_req = 0, c_sel = 0, c_hi = 0, c_lo = 0, exp_sel = 0;

  function automatic logic [NCH-1:0] pat(input int idx);
    int v;
    v = idx * 29 + (idx >>> 2) * 5 + 3;
    return NCH'(v ^ (idx >>> 4));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_model();
    pb = 0; pw = 0; pi = 0; ps = 0; par = 0; flag = 0; sel = 0; st = 0; ea = -1;
    a_val = '0; b_val = '0;
    c_valid = 0; c_req = 0; c_sel = 0; c_hi = 0; c_lo = 0;
  endtask

  task automatic evaluate();
    if (c_valid) begin
      chk(filt_valid_o == 1'b1, "R5", "valid strobe", 32'(filt_valid_o), 32'd1);
      chk(filt_data_o == exp_data, "R5 (R1,R2)", "word data", 32'(filt_data_o), 32'(exp_data));
    end else if (filt_valid_o) begin
      chk(1'b0, "R5", "stray valid", 32'd1, 32'd0);
    end
    if (c_req) chk(mute_o == 1'b1, "R7", "mute after request", 32'(mute_o), 32'd1);
    if (c_sel) chk(sel_b_o == exp_sel, "R4 (R3)", "applied select", 32'(sel_b_o), 32'(exp_sel));
    if (c_hi)  chk(mute_o == 1'b1, "R6", "mute before last boundary", 32'(mute_o), 32'd1);
    if (c_lo)  chk(mute_o == 1'b0, "R6", "mute release", 32'(mute_o), 32'd0);
    c_valid = 0; c_req = 0; c_sel = 0; c_hi = 0; c_lo = 0;
  endtask

  task automatic drive();
    bit bv, wv, br, bf, we, rq;
    logic [NCH-1:0] dv;
    cyc++;
    bv = ((cyc + boff) % 8) < 4;
    wv = (cyc % WP) < (WP / 2);
    dv = pat((cyc + boff + 2) / 8);
    dsd_bclk_i = bv; word_clk_i = wv; dsd_data_i = dv;
    init_ni = drv_init; resync_i = drv_sync;
    br = bv & !pb; bf = !bv & pb; we = wv & !pw;
    rq = (drv_init & !pi) | (drv_sync & !ps);
    if (we) begin
      c_valid = 1;
      exp_data = (((st == 2) && !rq) ? flag : sel) ? b_val : a_val;
    end
    if (rq) begin
      st = 1; c_req = 1; ea = -1;
    end else if (st == 1 && bf) begin
      flag = par; st = 2;
    end else if (st == 2 && we) begin
      sel = flag; st = 0; c_sel = 1; exp_sel = flag; ea = 0; mute_n = mute_exp;
    end else if (we && ea >= 0) begin
      ea++;
      if (ea == mute_n - 1) c_hi = 1;
      if (ea == mute_n) begin c_lo = 1; ea = -1; end
    end
    if (bf) b_val = a_val;
    if (br) begin a_val = dv; par = !par; end
    pb = bv; pw = wv; pi = drv_init; ps = drv_sync;
  endtask

  task automatic tick();
    @(negedge clk_i);
    evaluate();
    drive();
  endtask

  task automatic settle();
    while (st != 0 || ea >= 0) tick();
    repeat (6) tick();
  endtask

  task automatic check_reset_outputs();
    chk(filt_valid_o == 1'b0, "R9", "reset valid", 32'(filt_valid_o), 32'd0);
    chk(filt_data_o == '0, "R9", "reset data", 32'(filt_data_o), 32'd0);
    chk(sel_b_o == 1'b0, "R9", "reset select", 32'(sel_b_o), 32'd0);
    chk(mute_o == 1'b0, "R9", "reset mute", 32'(mute_o), 32'd0);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check_reset_outputs();
    rst_ni = 1; clear_model(); drive();
    repeat (20) tick();

    // table of scenarios
    for (int i = 0; i < NV; i++) begin
      boff = VEC[i][0]; rate_i = 2'(VEC[i][1]); mute_exp = VEC[i][4];
      repeat (VEC[i][3] + 4) tick();
      if (VEC[i][2] != 0) begin
        drv_init = 0; repeat (8) tick(); drv_init = 1;
      end else begin
        drv_sync = 1; repeat (8) tick(); drv_sync = 0;
      end
      settle();
    end

    // R8: request while waiting for the word boundary restarts the sequence
    boff = 4; rate_i = 2'd0; mute_exp = 10;
    drv_init = 0; repeat (8) tick();
    drv_sync = 1; tick();
    while (st != 2) tick();
    drv_init = 1; tick();
    chk(st == 1, "R8", "restart after second request", 32'(st), 32'd1);
    repeat (6) tick(); drv_sync = 0;
    settle();

    // R8: request on the same cycle as a bit-clock falling edge
    boff = 1; rate_i = 2'd1; mute_exp = 18;
    while (((cyc + 1 + boff) % 8) != 4) tick();
    drv_sync = 1; tick();
    chk(st == 1, "R8", "request beats falling edge", 32'(st), 32'd1);
    repeat (7) tick(); drv_sync = 0;
    settle();

    // R9: asynchronous reset in the middle of a mute window
    rate_i = 2'd2; mute_exp = 36;
    drv_sync = 1; repeat (8) tick(); drv_sync = 0;
    while (st != 0) tick();
    repeat (5) tick();
    rst_ni = 0; #1;
    check_reset_outputs();
    repeat (2) @(negedge clk_i);
    rst_ni = 1; clear_model(); drive();
    repeat (50) tick();
    drv_sync = 1; repeat (8) tick(); drv_sync = 0;
    settle();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule